// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block is one general-purpose I/O port of up to eight pins behind a small synchronous register bus. Each pin has a stored output value, a direction bit, a pull-device enable, a polarity bit, an interrupt enable, an interrupt flag and an open-drain (wired-OR) bit. The block drives the pad-side output value, output enable, pull enable and pull direction. It also raises one interrupt line when a pin shows its selected edge. A per-pin "peripheral owns pin" input hands a pin's output value and direction to a peripheral. The synchronized pin level stays readable in that case.

A parameter mask marks which pins exist. Two further parameters decide whether the port has interrupt capability and whether it has the wired-OR mode. Software drives the port through register writes and reads. The pads and the interrupt line follow the stored configuration.

Bus accesses pass through a three-state access FSM of type `acc_state_t`:
- `ACC_IDLE`: no access is pending. Read data is zero.
- `ACC_WRITE`: the write request captured in the previous cycle is applied to its register.
- `ACC_READ`: the register addressed in the previous cycle is placed on the read-data port.

A new request on any cycle moves the FSM to `ACC_WRITE` or `ACC_READ`, depending on `bus_wr`. With no request the FSM returns to `ACC_IDLE`. Every transition is taken from any state.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset, all configuration registers and interrupt flags are 0. `pad_oe`, `pad_out`, `pad_pull_en` and `irq` are 0, and `bus_rdata` is 0.
- R2: Reading the data register returns the stored bit for pins whose direction bit is 1. It returns the synchronized pin level for pins whose direction bit is 0. `pad_out` carries the stored bit and `pad_oe` the direction bit when wired-OR is off.
- R3: The input register always returns the synchronized pin level, including on peripheral-owned pins. Writes to it are ignored.
- R4: All writable registers accept writes at any time, even when the setting cannot take effect in the current pin mode. Such a value reads back as written.
- R5: `pad_pull_en` is 0 on any pin that drives as a push-pull output (effective direction 1 and wired-OR 0), whatever its pull-enable bit holds.
- R6: On an interrupt-capable port, the polarity bit selects the interrupt edge, and the pull direction is pull-up for the falling edge. `pad_pull_up` = inverted polarity bit. On a port without interrupt capability, `pad_pull_up` equals the polarity bit.
- R7: Unimplemented pins, given by `IMPL_MASK`, read 0 in every register and ignore writes. Their pad outputs and flags stay 0.
- R8: In wired-OR mode, an output pin never drives high. `pad_out` is 0, and `pad_oe` is 1 only while the pin's effective data bit is 0.
- R9: When `periph_own` is 1 for a pin, its effective output value and direction come from `periph_out` and `periph_dir`.
- R10: Pin inputs pass through a two-flop synchronizer. A flag sets only on the edge its polarity bit selects: 0 means falling, 1 means rising.
- R11: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R12: `irq` is the OR of all flags that are both set and enabled.
- R13: A request sampled on a clock edge is served in the next cycle: a write takes effect at the following edge, and read data is valid on `bus_rdata` for that cycle only, otherwise 0. The map is 0 data, 1 input, 2 direction, 3 pull enable, 4 polarity, 5 interrupt enable, 6 flags, 7 wired-OR, with bit n for pin n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register index |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, valid the cycle after a read request |
| pin_in | input | NPINS | Asynchronous pin levels |
| periph_own | input | NPINS | Peripheral owns pin |
| periph_out | input | NPINS | Peripheral output value |
| periph_dir | input | NPINS | Peripheral direction (1 = drive) |
| pad_out | output | NPINS | Pad output value |
| pad_oe | output | NPINS | Pad output enable |
| pad_pull_en | output | NPINS | Pull device enable |
| pad_pull_up | output | NPINS | Pull direction (1 = up) |
| irq | output | 1 | Port interrupt |

## Verification
The flag assertion assumes that `pin_in` is the only source of edges. It also assumes that an edge reaches the flags only through the synchronizer, so a new flag bit must always follow a detected edge one cycle earlier.

The pad assertions assume nothing about `periph_own`. They check the pull and wired-OR rules against the effective drive, whoever owns the pin.

The stimulus changes `pin_in` only on falling clock edges and holds each level for several cycles, so each change yields exactly one synchronized edge. It never issues a bus request in the cycle in which read data is being sampled.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_state_t;

    localparam int unsigned RA_DATA  = 0;
    localparam int unsigned RA_INPUT = 1;
    localparam int unsigned RA_DIR   = 2;
    localparam int unsigned RA_PULL  = 3;
    localparam int unsigned RA_POL   = 4;
    localparam int unsigned RA_IEN   = 5;
    localparam int unsigned RA_FLAG  = 6;
    localparam int unsigned RA_WOM   = 7;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] pol,
    output logic [NPINS-1:0] pin_sync,
    output logic [NPINS-1:0] edge_hit
);
    logic [NPINS-1:0] meta_q;
    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= pin_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign pin_sync = sync_q;

    // per-pin edge selection: polarity 1 = rising, 0 = falling
    for (genvar i = 0; i < NPINS; i++) begin : g_edge
        always_comb begin
            if (pol[i]) edge_hit[i] = sync_q[i] & ~last_q[i];
            else        edge_hit[i] = ~sync_q[i] & last_q[i];
        end
    end
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_port_pkg::*;
#(
    parameter int               NPINS     = 8,
    parameter logic [NPINS-1:0] IMPL_MASK = '1,
    parameter bit               IRQ_CAP   = 1'b1,
    parameter bit               WOM_CAP   = 1'b1,
    parameter int               ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_sync,
    input  logic [NPINS-1:0]  edge_hit,
    output logic [NPINS-1:0]  data_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  pull_q,
    output logic [NPINS-1:0]  pol_q,
    output logic [NPINS-1:0]  ien_q,
    output logic [NPINS-1:0]  flag_q,
    output logic [NPINS-1:0]  wom_q
);
    localparam logic [NPINS-1:0] IRQ_M = IRQ_CAP ? IMPL_MASK : '0;
    localparam logic [NPINS-1:0] WOM_M = WOM_CAP ? IMPL_MASK : '0;

    acc_state_t        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [NPINS-1:0]  wdata_q;

    logic we_data, we_dir, we_pull, we_pol, we_ien, we_flag, we_wom;
    logic [NPINS-1:0] rd_word;

    // next-state selection
    always_comb begin
        if (!bus_req)    state_nx = ACC_IDLE;
        else if (bus_wr) state_nx = ACC_WRITE;
        else             state_nx = ACC_READ;
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ACC_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state <= state_nx;
            if (bus_req) begin
                addr_q  <= bus_addr;
                wdata_q <= bus_wdata;
            end
        end
    end

    // read selection
    always_comb begin
        case (addr_q)
            ADDR_W'(RA_DATA):  rd_word = (dir_q & data_q) | (~dir_q & pin_sync);
            ADDR_W'(RA_INPUT): rd_word = pin_sync;
            ADDR_W'(RA_DIR):   rd_word = dir_q;
            ADDR_W'(RA_PULL):  rd_word = pull_q;
            ADDR_W'(RA_POL):   rd_word = pol_q;
            ADDR_W'(RA_IEN):   rd_word = ien_q;
            ADDR_W'(RA_FLAG):  rd_word = flag_q;
            ADDR_W'(RA_WOM):   rd_word = wom_q;
            default:           rd_word = '0;
        endcase
    end

    // outputs of the access FSM
    always_comb begin
        we_data   = 1'b0;
        we_dir    = 1'b0;
        we_pull   = 1'b0;
        we_pol    = 1'b0;
        we_ien    = 1'b0;
        we_flag   = 1'b0;
        we_wom    = 1'b0;
        bus_rdata = '0;
        unique case (state)
            ACC_IDLE: ;
            ACC_WRITE: begin
                case (addr_q)
                    ADDR_W'(RA_DATA): we_data = 1'b1;
                    ADDR_W'(RA_DIR):  we_dir  = 1'b1;
                    ADDR_W'(RA_PULL): we_pull = 1'b1;
                    ADDR_W'(RA_POL):  we_pol  = 1'b1;
                    ADDR_W'(RA_IEN):  we_ien  = 1'b1;
                    ADDR_W'(RA_FLAG): we_flag = 1'b1;
                    ADDR_W'(RA_WOM):  we_wom  = 1'b1;
                    default: ;
                endcase
            end
            ACC_READ: bus_rdata = rd_word & IMPL_MASK;
            default: ;
        endcase
    end

    // configuration storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            pull_q <= '0;
            pol_q  <= '0;
            ien_q  <= '0;
            wom_q  <= '0;
        end else begin
            if (we_data) data_q <= wdata_q & IMPL_MASK;
            if (we_dir)  dir_q  <= wdata_q & IMPL_MASK;
            if (we_pull) pull_q <= wdata_q & IMPL_MASK;
            if (we_pol)  pol_q  <= wdata_q & IMPL_MASK;
            if (we_ien)  ien_q  <= wdata_q & IRQ_M;
            if (we_wom)  wom_q  <= wdata_q & WOM_M;
        end
    end

    // flags: an edge sets, writing one clears, setting wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= '0;
        end else begin
            flag_q <= ((flag_q & ~(we_flag ? wdata_q : '0)) | edge_hit) & IRQ_M;
        end
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int               NPINS     = 8,
    parameter logic [NPINS-1:0] IMPL_MASK = '1,
    parameter bit               IRQ_CAP   = 1'b1
) (
    input  logic [NPINS-1:0] data_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] pull_q,
    input  logic [NPINS-1:0] pol_q,
    input  logic [NPINS-1:0] wom_q,
    input  logic [NPINS-1:0] periph_own,
    input  logic [NPINS-1:0] periph_out,
    input  logic [NPINS-1:0] periph_dir,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] pad_pull_en,
    output logic [NPINS-1:0] pad_pull_up
);
    logic [NPINS-1:0] eff_dat;
    logic [NPINS-1:0] eff_dir;
    logic [NPINS-1:0] push_pull;

    always_comb begin
        eff_dat   = (periph_own & periph_out) | (~periph_own & data_q);
        eff_dir   = (periph_own & periph_dir) | (~periph_own & dir_q);
        push_pull = eff_dir & ~wom_q;
        pad_out     = eff_dat & ~wom_q & IMPL_MASK;
        pad_oe      = eff_dir & ~(wom_q & eff_dat) & IMPL_MASK;
        pad_pull_en = pull_q & ~push_pull & IMPL_MASK;
    end

    if (IRQ_CAP) begin : g_edge_pol
        assign pad_pull_up = ~pol_q & IMPL_MASK;
    end else begin : g_pull_pol
        assign pad_pull_up = pol_q & IMPL_MASK;
    end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl #(
    parameter int               NPINS     = 8,
    parameter logic [NPINS-1:0] IMPL_MASK = '1,
    parameter bit               IRQ_CAP   = 1'b1,
    parameter bit               WOM_CAP   = 1'b1,
    parameter int               ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [NPINS-1:0]  periph_own,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  periph_dir,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic [NPINS-1:0]  pad_pull_en,
    output logic [NPINS-1:0]  pad_pull_up,
    output logic              irq
);
    logic [NPINS-1:0] pin_sync, edge_hit;
    logic [NPINS-1:0] data_q, dir_q, pull_q, pol_q, ien_q, flag_q, wom_q;

    gpio_pin_sync #(.NPINS(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pol      (pol_q),
        .pin_sync (pin_sync),
        .edge_hit (edge_hit)
    );

    gpio_regbank #(
        .NPINS(NPINS), .IMPL_MASK(IMPL_MASK), .IRQ_CAP(IRQ_CAP),
        .WOM_CAP(WOM_CAP), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_sync  (pin_sync),
        .edge_hit  (edge_hit),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .pull_q    (pull_q),
        .pol_q     (pol_q),
        .ien_q     (ien_q),
        .flag_q    (flag_q),
        .wom_q     (wom_q)
    );

    gpio_pad_mux #(
        .NPINS(NPINS), .IMPL_MASK(IMPL_MASK), .IRQ_CAP(IRQ_CAP)
    ) u_pads (
        .data_q      (data_q),
        .dir_q       (dir_q),
        .pull_q      (pull_q),
        .pol_q       (pol_q),
        .wom_q       (wom_q),
        .periph_own  (periph_own),
        .periph_out  (periph_out),
        .periph_dir  (periph_dir),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .pad_pull_en (pad_pull_en),
        .pad_pull_up (pad_pull_up)
    );

    assign irq = |(flag_q & ien_q);
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
    parameter int               NPINS     = 8,
    parameter logic [NPINS-1:0] IMPL_MASK = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pull_en,
    input logic [NPINS-1:0] bus_rdata,
    input logic [NPINS-1:0] wom_q,
    input logic [NPINS-1:0] flag_q,
    input logic [NPINS-1:0] ien_q,
    input logic [NPINS-1:0] edge_hit,
    input logic             irq
);
    // R5
    pull_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe & ~wom_q) == '0);

    // R8
    wired_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & wom_q) == '0);

    // R7
    unimpl_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_out | pad_pull_en | bus_rdata | flag_q) & ~IMPL_MASK) == '0);

    // R10
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q)) & ~$past(edge_hit)) == '0);

    // R12
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ien_q) == '0) |-> !irq);
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(.NPINS(NPINS), .IMPL_MASK(IMPL_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en),
    .bus_rdata   (bus_rdata),
    .wom_q       (wom_q),
    .flag_q      (flag_q),
    .ien_q       (ien_q),
    .edge_hit    (edge_hit),
    .irq         (irq)
);

// File: tb/tb_gpio_port_ctl.sv
module tb_gpio_port_ctl;
    localparam int         NP   = 8;
    localparam logic [7:0] IMPL = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0, bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] pin_in = '0, periph_own = '0, periph_out = '0, periph_dir = '0;
    logic [7:0] pad_out, pad_oe, pad_pull_en, pad_pull_up;
    logic       irq;

    int  checks = 0, errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    gpio_port_ctl #(.NPINS(NP), .IMPL_MASK(IMPL), .IRQ_CAP(1'b1), .WOM_CAP(1'b1), .ADDR_W(3)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .periph_own(periph_own), .periph_out(periph_out),
        .periph_dir(periph_dir), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull_en(pad_pull_en), .pad_pull_up(pad_pull_up), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pull_en", pad_pull_en, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        rd(2, v);
        check("R1 dir reg", v, 8'h00);
        @(negedge clk);
        check("R13 rdata idle", bus_rdata, 8'h00);
    endtask

    task automatic t_data_read();
        logic [7:0] v;
        wr(2, 8'h0F);
        wr(0, 8'hA5);
        pin_in = 8'h30;
        settle();
        rd(0, v);
        check("R2 data read mix", v, 8'h35);
        check("R2 pad_out", pad_out, 8'h25);
        check("R2 pad_oe", pad_oe, 8'h0F);
    endtask

    task automatic t_periph();
        logic [7:0] v;
        periph_own = 8'h03; periph_dir = 8'h01; periph_out = 8'h03;
        pin_in = 8'h2A;
        settle();
        rd(1, v);
        check("R3 input reg", v, 8'h2A);
        check("R9 pad_out", pad_out, 8'h27);
        check("R9 pad_oe", pad_oe, 8'h0D);
        wr(1, 8'hFF);
        rd(1, v);
        check("R3 input write ignored", v, 8'h2A);
        periph_own = 8'h00;
        pin_in = 8'h00;
        settle();
    endtask

    task automatic t_pull_wom();
        logic [7:0] v;
        wr(3, 8'h3F);
        rd(3, v);
        check("R4 pull readback", v, 8'h3F);
        check("R5 pull masked", pad_pull_en, 8'h30);
        wr(4, 8'h05);
        check("R6 pull dir", pad_pull_up, 8'h3A);
        wr(7, 8'h03);
        check("R8 wom oe", pad_oe, 8'h0E);
        check("R8 wom out", pad_out, 8'h24);
        check("R5 pull open drain", pad_pull_en, 8'h33);
        wr(7, 8'h00);
        wr(3, 8'h00);
        wr(4, 8'h00);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        wr(2, 8'hFF);
        rd(2, v);
        check("R7 dir masked", v, 8'h3F);
        check("R7 pad_oe masked", pad_oe, 8'h3F);
        wr(2, 8'h00);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        wr(6, 8'hFF);
        rd(6, v);
        check("R11 flags cleared", v, 8'h00);
        wr(5, 8'h3F);
        wr(4, 8'h01);
        pin_in = 8'h01; settle();
        rd(6, v);
        check("R10 rising pin0", v, 8'h01);
        check("R12 irq set", {7'b0, irq}, 8'h01);
        pin_in = 8'h00; settle();
        rd(6, v);
        check("R10 falling pin0 ignored", v, 8'h01);
        pin_in = 8'h02; settle();
        pin_in = 8'h00; settle();
        rd(6, v);
        check("R10 falling pin1", v, 8'h03);
        pin_in = 8'h80; settle();
        pin_in = 8'h00; settle();
        rd(6, v);
        check("R7 pin7 no flag", v, 8'h03);
        wr(6, 8'h01);
        rd(6, v);
        check("R11 w1c", v, 8'h02);
        wr(6, 8'h00);
        rd(6, v);
        check("R11 write0 kept", v, 8'h02);
        wr(5, 8'h01);
        check("R12 irq masked", {7'b0, irq}, 8'h00);
        wr(5, 8'h02);
        check("R12 irq enabled", {7'b0, irq}, 8'h01);
        wr(6, 8'hFF);
        check("R12 irq cleared", {7'b0, irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_read();
        t_periph();
        t_pull_wom();
        t_unimpl();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule